// File: doc/BRIEF.md
# Serial Peripheral Port with Collision and Mode-Fault Detection

This block is an 8-bit full-duplex synchronous serial port that works either as the clock-driving master or as a slave clocked from outside. Each bit slot sends one bit and receives one bit at the same time, most significant bit first, on two separate data lines. Software sets the clock idle level and the phase in which bits are sampled. In master mode it also picks one of four bit rates, the fastest being the system clock divided by 8. The host reaches the block through a small register port with three addresses: control, status and data. A single interrupt request covers both the end of a byte and a bus fault.

The block protects itself in two ways. If the data register is written while a byte is still moving, the write is dropped and a collision flag is set. If the active-low select input goes low while the block is master, another device is trying to drive the bus. The block then clears its master bit, releases its clock driver and raises a fault flag. In slave mode, the slave data output is driven only while the select input is low.

Top module: `spi_port`

## Requirements
- R1: After reset, control (address 0) and status (address 1) read 0, `irq` is low, and `sck_oe` and `s_out_oe` are low.
- R2: In master mode, a write to the data address (2) sends the byte on `m_out`, most significant bit first, and samples `m_in` at the same time. When the byte is done, a read of address 2 returns the 8 received bits.
- R3: Control bit 3 (clock polarity) sets the level of `sck_out` between bytes. With control bit 2 (phase) at 0, the first bit is on the line before the first clock edge, and bits are sampled on leading edges. With phase at 1, data changes on leading edges and is sampled on trailing edges.
- R4: Control bits 1:0 set the master bit rate. Values 0, 1, 2 and 3 give `sck_out` half periods of 4, 8, 32 and 64 system clocks, which is clk/8, clk/16, clk/64 and clk/128.
- R5: A write to the data address while a byte is in flight sets status bit 6 (collision). That write is dropped, and the byte in flight goes on unchanged.
- R6: Status bit 7 (done) is set after the eighth bit. `irq` equals control bit 7 (interrupt enable) ANDed with (done OR fault). Done and collision clear when the status register is read and then the data address is accessed.
- R7: While control bit 6 (enable) and bit 4 (master) are set, a low `ss_n` clears the master bit, drops `sck_oe` and sets status bit 4 (fault). The fault clears when the status register is read and then the control register is written.
- R8: In slave mode (enable set, master clear), a byte clocked in on `sck_in`/`s_in` while `ss_n` is low lands in the data register. At the same time, the previously written byte goes out on `s_out`. Done is then set.
- R9: `s_out_oe` is high only while the block is enabled, not master, and `ss_n` is low. `sck_oe` is high only while the block is enabled and master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| m_in | input | 1 | Master-mode serial data input |
| m_out | output | 1 | Master-mode serial data output |
| s_in | input | 1 | Slave-mode serial data input |
| s_out | output | 1 | Slave-mode serial data output |
| s_out_oe | output | 1 | Output enable for s_out |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_out |
| ss_n | input | 1 | Active-low slave select |

## Verification
The bench covers all four polarity/phase pairings, each with a different rate. A bit-order or phase error would show as a garbled byte on one side of the link. A wrong rate would show as a half period that does not match the selected divisor. A second data write in the middle of a byte must set the collision flag and leave the outgoing byte intact. A design that reloaded the shifter would put the second byte on the wire instead. A low select while in master mode must clear the master bit and the clock enable. A design that only set the flag would keep fighting for the bus. The done flag is cleared only through the status-then-data sequence, and the bench checks the flag both before and after that sequence.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [7:0] b);
        ctrl_t c;
        c.ie     = b[7];
        c.en     = b[6];
        c.master = b[4];
        c.cpol   = b[3];
        c.cpha   = b[2];
        c.rate   = b[1:0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_pack(input ctrl_t c);
        return {c.ie, c.en, 1'b0, c.master, c.cpol, c.cpha, c.rate};
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) st_q[i] <= RST_VAL;
            else        st_q[i] <= st_d[i];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int BASE_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int HALF0 = BASE_DIV / 2;
    localparam int HALF1 = HALF0 * 2;
    localparam int HALF2 = HALF0 * 8;
    localparam int HALF3 = HALF0 * 16;
    localparam int CNT_W = $clog2(HALF3);

    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        case (sel)
            2'd0:    lim = CNT_W'(HALF0 - 1);
            2'd1:    lim = CNT_W'(HALF1 - 1);
            2'd2:    lim = CNT_W'(HALF2 - 1);
            default: lim = CNT_W'(HALF3 - 1);
        endcase
        tick  = run && (cnt_q == lim);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       master,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       start,
    input  logic [7:0] tx_data,
    input  logic       tick,
    input  logic       mi,
    input  logic       sck_s,
    input  logic       si_s,
    input  logic       ss_s,
    output logic       busy,
    output logic       mrun,
    output logic       done,
    output logic [7:0] byte_out,
    output logic       sck_o,
    output logic       tx_bit
);
    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] rx;
        logic [3:0] cnt;
        logic       mrun;
        logic       sck;
        logic       sck_prev;
    } core_t;

    core_t q, d;
    logic  master_mode, ev, bit_in;

    assign master_mode = en && master;

    always_comb begin
        d      = q;
        done   = 1'b0;
        ev     = 1'b0;
        bit_in = 1'b0;
        if (master_mode) begin
            bit_in = mi;
            ev     = q.mrun && tick;
            if (!q.mrun) d.sck = cpol;
            else if (ev) d.sck = ~q.sck;
        end else begin
            bit_in = si_s;
            ev     = en && !ss_s && (sck_s != q.sck_prev);
            d.mrun = 1'b0;
            d.sck  = cpol;
            if (ss_s || !en || q.mrun) begin
                d.cnt = '0;
                ev    = 1'b0;
            end
        end
        d.sck_prev = sck_s;
        if (ev) begin
            if (q.cnt[0] == cpha)
                d.rx = {q.rx[6:0], bit_in};
            else if (!(cpha && q.cnt == 4'd0))
                d.tx = {q.tx[6:0], 1'b0};
            d.cnt = q.cnt + 4'd1;
            if (q.cnt == 4'hF) begin
                done   = 1'b1;
                d.mrun = 1'b0;
                if (master_mode) d.sck = cpol;
            end
        end
        if (start) begin
            d.tx   = tx_data;
            d.cnt  = '0;
            d.mrun = master_mode;
            d.sck  = cpol;
        end
        byte_out = d.rx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.mrun || (!master_mode && q.cnt != 4'd0);
    assign mrun   = q.mrun;
    assign sck_o  = q.sck;
    assign tx_bit = q.tx[7];

    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !q.mrun && !start) |=> (sck_o == $past(cpol)));

    p_done_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (q.cnt == 4'd0 && !q.mrun));
endmodule

// File: rtl/spi_port.sv
module spi_port #(
    parameter int BASE_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       m_in,
    output logic       m_out,
    input  logic       s_in,
    output logic       s_out,
    output logic       s_out_oe,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       sck_oe,
    input  logic       ss_n
);
    import spi_port_pkg::*;

    typedef struct packed {
        ctrl_t      ctrl;
        logic       done;
        logic       wcol;
        logic       modf;
        logic [7:0] rxbuf;
        logic       dat_arm;
        logic       modf_arm;
    } regs_t;

    regs_t q, d;

    logic       sck_s, si_s, ss_s;
    logic       tick, busy, mrun, done_p, tx_bit, core_sck;
    logic [7:0] rx_byte;
    logic       data_wr, data_acc, start;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_in, s_in, ss_n}),
        .dout ({sck_s, si_s, ss_s})
    );

    spi_rate_gen #(.BASE_DIV(BASE_DIV)) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (mrun),
        .sel  (q.ctrl.rate),
        .tick (tick)
    );

    spi_shift_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (q.ctrl.en),
        .master  (q.ctrl.master),
        .cpol    (q.ctrl.cpol),
        .cpha    (q.ctrl.cpha),
        .start   (start),
        .tx_data (bus_wdata),
        .tick    (tick),
        .mi      (m_in),
        .sck_s   (sck_s),
        .si_s    (si_s),
        .ss_s    (ss_s),
        .busy    (busy),
        .mrun    (mrun),
        .done    (done_p),
        .byte_out(rx_byte),
        .sck_o   (core_sck),
        .tx_bit  (tx_bit)
    );

    always_comb begin
        d        = q;
        data_wr  = bus_wr && (bus_addr == ADR_DATA);
        data_acc = (bus_wr || bus_rd) && (bus_addr == ADR_DATA);
        start    = data_wr && q.ctrl.en && !busy;

        if (bus_rd && bus_addr == ADR_STAT) begin
            d.dat_arm  = q.done || q.wcol;
            d.modf_arm = q.modf;
        end
        if (data_acc && q.dat_arm) begin
            d.done    = 1'b0;
            d.wcol    = 1'b0;
            d.dat_arm = 1'b0;
        end
        if (bus_wr && bus_addr == ADR_CTRL) begin
            d.ctrl = ctrl_unpack(bus_wdata);
            if (q.modf_arm) begin
                d.modf     = 1'b0;
                d.modf_arm = 1'b0;
            end
        end
        if (done_p) begin
            d.done  = 1'b1;
            d.rxbuf = rx_byte;
        end
        if (data_wr && q.ctrl.en && busy) d.wcol = 1'b1;
        if (q.ctrl.en && q.ctrl.master && !ss_s) begin
            d.ctrl.master = 1'b0;
            d.modf        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl_pack(q.ctrl);
            ADR_STAT: bus_rdata = {q.done, q.wcol, 1'b0, q.modf, 4'b0000};
            ADR_DATA: bus_rdata = q.rxbuf;
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq      = q.ctrl.ie && (q.done || q.modf);
    assign sck_out  = core_sck;
    assign sck_oe   = q.ctrl.en && q.ctrl.master;
    assign m_out    = tx_bit;
    assign s_out    = tx_bit;
    assign s_out_oe = q.ctrl.en && !q.ctrl.master && !ss_s;

    p_drv_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_oe && s_out_oe));

    p_fault_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.en && q.ctrl.master && !ss_s) |=> (!sck_oe && q.modf));

    p_wcol_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && q.ctrl.en && busy) |=> q.wcol);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> q.ctrl.ie);
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
    localparam int CLK_PERIOD = 10;
    localparam int SLV_HALF   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, m_in, m_out, s_in, s_out, s_out_oe;
    logic       sck_in, sck_out, sck_oe, ss_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];

    logic       mdl_arm = 1'b0;
    logic       mdl_cpha = 1'b0;
    logic [7:0] mdl_stx = 8'h00;
    logic [7:0] mdl_obs = 8'h00;
    int         mdl_cnt = 0;
    int         cyc = 0, last_edge = 0, gap = 0;
    logic       prev_sck = 1'b0;
    logic       m_in_r = 1'b0;

    assign m_in = m_in_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .m_in(m_in), .m_out(m_out), .s_in(s_in), .s_out(s_out),
        .s_out_oe(s_out_oe), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .ss_n(ss_n)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: serial slave model for master-mode runs; pops the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (mdl_arm && sck_oe && sck_out != prev_sck) begin
            gap = cyc - last_edge;
            last_edge = cyc;
            if ((mdl_cnt % 2) == int'(mdl_cpha)) begin
                mdl_obs = {mdl_obs[6:0], m_out};
            end else if (!(mdl_cpha && mdl_cnt == 0)) begin
                mdl_stx = {mdl_stx[6:0], 1'b0};
                m_in_r = mdl_stx[7];
            end
            mdl_cnt++;
            if (mdl_cnt == 16) begin
                mdl_cnt = 0;
                mdl_arm = 1'b0;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 actual=%h expected=<none>", mdl_obs);
                end else begin
                    chk(mdl_obs, exp_q.pop_front(), "R2 master byte on m_out");
                end
            end
        end
        prev_sck = sck_out;
    end

    task automatic master_xfer(input logic [7:0] ctrl, input logic [7:0] mbyte,
                               input logic [7:0] sbyte, input int half);
        logic [7:0] v;
        wr(2'd0, ctrl);
        idle(3);
        chk({7'd0, sck_out}, {7'd0, ctrl[3]}, "R3 idle clock level");
        exp_q.push_back(mbyte);
        mdl_cpha = ctrl[2];
        mdl_stx  = sbyte;
        m_in_r   = sbyte[7];
        mdl_cnt  = 0;
        prev_sck = sck_out;
        mdl_arm  = 1'b1;
        wr(2'd2, mbyte);
        idle(16 * half + 6);
        chk(8'(gap), 8'(half), "R4 half period");
        chk({7'd0, irq}, 8'h01, "R6 irq on done");
        rd(2'd1, v);
        chk(v, 8'h80, "R6 done flag");
        rd(2'd2, v);
        chk(v, sbyte, "R2 received byte");
        rd(2'd1, v);
        chk(v, 8'h00, "R6 flags cleared");
        chk({7'd0, irq}, 8'h00, "R6 irq cleared");
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] mbyte, input logic [7:0] txbyte);
        logic [7:0] b, obs, v;
        wr(2'd0, {1'b0, 1'b1, 2'b00, cpol, cpha, 2'b00});
        sck_in = cpol;
        wr(2'd2, txbyte);
        exp_q.push_back(txbyte);
        idle(4);
        chk({7'd0, s_out_oe}, 8'h00, "R9 slave out off while deselected");
        b = mbyte;
        obs = 8'h00;
        ss_n = 1'b0;
        s_in = b[7];
        idle(4);
        chk({7'd0, s_out_oe}, 8'h01, "R9 slave out on while selected");
        chk({7'd0, sck_oe}, 8'h00, "R9 no clock drive in slave mode");
        idle(SLV_HALF);
        for (int e = 0; e < 16; e++) begin
            if ((e % 2) == int'(cpha)) obs = {obs[6:0], s_out};
            sck_in = ~sck_in;
            if ((e % 2) != int'(cpha) && !(cpha && e == 0)) begin
                b = {b[6:0], 1'b0};
                s_in = b[7];
            end
            idle(SLV_HALF);
        end
        idle(SLV_HALF);
        ss_n = 1'b1;
        chk(obs, exp_q.pop_front(), "R8 slave byte on s_out");
        idle(4);
        rd(2'd1, v);
        chk(v, 8'h80, "R8 done after slave byte");
        chk({7'd0, irq}, 8'h00, "R6 no irq with enable clear");
        rd(2'd2, v);
        chk(v, mbyte, "R8 slave received byte");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        ss_n = 1'b1; sck_in = 1'b0; s_in = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v); chk(v, 8'h00, "R1 control after reset");
        rd(2'd1, v); chk(v, 8'h00, "R1 status after reset");
        chk({7'd0, irq}, 8'h00, "R1 irq after reset");
        chk({6'd0, sck_oe, s_out_oe}, 8'h00, "R1 drivers after reset");

        // R2 R3 R4 R6 four clock modes at four rates
        master_xfer(8'hD0, 8'hA5, 8'h3C, 4);
        master_xfer(8'hD9, 8'h81, 8'h7E, 8);
        master_xfer(8'hD6, 8'h5A, 8'hC3, 32);
        master_xfer(8'hDF, 8'h01, 8'hF0, 64);
        chk({7'd0, sck_oe}, 8'h01, "R9 clock drive in master mode");

        // R5 write collision
        wr(2'd0, 8'hD0);
        idle(3);
        exp_q.push_back(8'h96);
        mdl_cpha = 1'b0; mdl_stx = 8'h69; m_in_r = 1'b0; mdl_cnt = 0;
        prev_sck = sck_out; mdl_arm = 1'b1;
        wr(2'd2, 8'h96);
        idle(10);
        wr(2'd2, 8'hFF);
        idle(16 * 4 + 6);
        rd(2'd1, v); chk(v, 8'hC0, "R5 collision and done flags");
        rd(2'd2, v); chk(v, 8'h69, "R5 byte in flight unchanged");
        rd(2'd1, v); chk(v, 8'h00, "R5 collision cleared");

        // R7 mode fault
        wr(2'd0, 8'hD0);
        idle(2);
        ss_n = 1'b0;
        idle(5);
        rd(2'd0, v); chk(v, 8'hC0, "R7 master bit cleared");
        chk({7'd0, sck_oe}, 8'h00, "R7 clock driver released");
        chk({7'd0, irq}, 8'h01, "R7 irq on fault");
        ss_n = 1'b1;
        idle(4);
        rd(2'd1, v); chk(v, 8'h10, "R7 fault flag");
        wr(2'd0, 8'hC0);
        rd(2'd1, v); chk(v, 8'h00, "R7 fault cleared");

        // R8 R9 slave mode, both phases
        slave_xfer(1'b0, 1'b0, 8'hA5, 8'h3C);
        slave_xfer(1'b1, 1'b1, 8'h4B, 8'hD2);

        idle(5);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule